// File: doc/BRIEF.md
# CRC-16 Checksum Engine for an Infrared Link Controller

This block is a register-mapped CRC accelerator. Software first clears it through the control register. It then writes data values one at a time into the input register. Each accepted value is folded into a running 16-bit frame check sequence in the same clock. The result register shows the conditioned checksum at all times. The control register also reports how many values have been absorbed since the last clear. That count lets software confirm that no write was lost.

The checksum uses the generator x^16 + x^12 + x^5 + 1. Bits enter least significant first, the state starts at all ones, and the output is complemented. This is the usual frame check sequence of asynchronous infrared framing. A fixed four-byte known-answer vector serves as a power-on self test.

The bus side is a simple single-cycle register port. There is no back-pressure: every write is taken on the clock edge where it is presented, and `bus_rdata` is valid in the same cycle as the read strobe. Data reaches the engine only as register writes, so the valid/ready rules reduce to "valid = bus_en & bus_we, ready = 1".

Top module: `crc16_engine`

## Requirements
- R1: After reset the absorbed-value count reads 0 and the result register reads 0x0000.
- R2: Writing the control register (word 0) with bit 15 set clears the checksum state and the count. A control write with bit 15 clear changes neither.
- R3: A read of the control register returns the count in bits 11:0, with bits 15:12 reading 0.
- R4: A write to the input register (word 1) absorbs bits 7:0 of the write data as one byte. Bits 15:8 have no effect on the result.
- R5: The result register (word 2) returns the bitwise complement of the running state. The state starts at 0xFFFF and is updated per byte, LSB first, with the reflected generator 0x8408.
- R6: After a clear, writing 0xCC, 0xF5, 0xF1 and 0xA7 in that order gives a count of 4 and a result of 0x51DF.
- R7: The count increments by one per input write and saturates at 4095.
- R8: Reads of the input register, of the unused word 3, and every cycle without a read strobe return 0.
- R9: With `bus_en` low, nothing changes the count or the checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 control, 1 input, 2 result |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |

## Verification
A corrupted checksum state shows up in the result register on the first read after the faulty update. The reference model compares every read, so the mismatch is caught in that same cycle. A miscounted or non-saturating counter shows in the control read-back right after the write that went wrong. The saturation run exposes a missing clamp once 4095 writes have been passed. Leakage of high data bits, or of writes without a strobe, also shows within one access.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 12;

  localparam logic [ADDR_W-1:0] WA_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] WA_DIN    = 2'd1;
  localparam logic [ADDR_W-1:0] WA_RESULT = 2'd2;

  localparam int CLR_BIT = 15;

  localparam logic [DATA_W-1:0] POLY_REFL = 16'h8408;
  localparam logic [DATA_W-1:0] SEED      = 16'hFFFF;
  localparam logic [DATA_W-1:0] OUT_XOR   = 16'hFFFF;
endpackage

// File: rtl/crc16_regdec.sv
module crc16_regdec
  import crc16_pkg::*;
(
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              clr_bit,
  output logic              clr_stb,
  output logic              din_stb,
  output logic              rd_ctrl,
  output logic              rd_result
);
  logic wr, rd;

  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;

  assign clr_stb   = wr & (bus_addr == WA_CTRL) & clr_bit;
  assign din_stb   = wr & (bus_addr == WA_DIN);
  assign rd_ctrl   = rd & (bus_addr == WA_CTRL);
  assign rd_result = rd & (bus_addr == WA_RESULT);
endmodule

// File: rtl/crc16_lfsr.sv
module crc16_lfsr #(
  parameter int                 W     = 16,
  parameter int                 BW    = 8,
  parameter logic [W-1:0]       POLY  = 16'h8408,
  parameter logic [W-1:0]       INIT  = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [BW-1:0] byte_in,
  output logic [W-1:0]  state_q
);
  logic [W-1:0] chain [BW+1];

  assign chain[0] = state_q;

  for (genvar i = 0; i < BW; i++) begin : g_stage
    logic fb;
    assign fb = chain[i][0] ^ byte_in[i];
    assign chain[i+1] = fb ? ((chain[i] >> 1) ^ POLY) : (chain[i] >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= INIT;
    else if (clr)    state_q <= INIT;
    else if (load)   state_q <= chain[BW];
  end
endmodule

// File: rtl/crc16_sat_cnt.sv
module crc16_sat_cnt #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt_q
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (clr)                 cnt_q <= '0;
    else if (inc && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc16_pkg::*;
#(
  parameter int                 CNT_BITS = CNT_W,
  parameter logic [DATA_W-1:0]  GEN      = POLY_REFL,
  parameter logic [DATA_W-1:0]  START    = SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int PAD_W = DATA_W - CNT_BITS;

  logic              clr_stb, din_stb, rd_ctrl, rd_result;
  logic [DATA_W-1:0] crc_q;
  logic [CNT_BITS-1:0] cnt_q;
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata[CLR_BIT-1:BYTE_W];

  crc16_regdec u_dec (
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .clr_bit  (bus_wdata[CLR_BIT]),
    .clr_stb  (clr_stb),
    .din_stb  (din_stb),
    .rd_ctrl  (rd_ctrl),
    .rd_result(rd_result)
  );

  crc16_lfsr #(.W(DATA_W), .BW(BYTE_W), .POLY(GEN), .INIT(START)) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_stb),
    .load   (din_stb),
    .byte_in(bus_wdata[BYTE_W-1:0]),
    .state_q(crc_q)
  );

  crc16_sat_cnt #(.CW(CNT_BITS)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_stb),
    .inc  (din_stb),
    .cnt_q(cnt_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_ctrl)        bus_rdata = {{PAD_W{1'b0}}, cnt_q};
    else if (rd_result) bus_rdata = crc_q ^ OUT_XOR;
  end
endmodule

// File: rtl/crc16_engine_chk.sv
module crc16_engine_chk
  import crc16_pkg::*;
#(
  parameter int           CW   = 12,
  parameter logic [15:0]  INIT = 16'hFFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CW-1:0]     cnt_q,
  input logic [DATA_W-1:0] crc_q
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};
  logic clr_w, din_w, ctl_noclr_w;

  assign clr_w       = bus_en && bus_we && bus_addr == WA_CTRL && bus_wdata[CLR_BIT];
  assign ctl_noclr_w = bus_en && bus_we && bus_addr == WA_CTRL && !bus_wdata[CLR_BIT];
  assign din_w       = bus_en && bus_we && bus_addr == WA_DIN;

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (cnt_q == '0 && crc_q == INIT)); // R2
  AST_CTRL_NOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_noclr_w |=> ($stable(cnt_q) && $stable(crc_q))); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (din_w && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1); // R7
  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (din_w && cnt_q == TOP) |=> cnt_q == TOP); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> ($stable(cnt_q) && $stable(crc_q))); // R9
  AST_NOREAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_we) |-> bus_rdata == '0); // R8
  AST_RESULT_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == WA_RESULT) |-> bus_rdata == ~crc_q); // R5
endmodule

bind crc16_engine crc16_engine_chk #(.CW(CNT_BITS), .INIT(START)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cnt_q(cnt_q), .crc_q(crc_q)
);

// File: tb/crc16_engine_tb_top.sv
module crc16_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int m_crc;
  int m_cnt;

  always #5 clk = ~clk;

  crc16_engine dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic int step_byte(int c, int b);
    int s = c;
    for (int k = 0; k < 8; k++) begin
      if (((s ^ (b >> k)) & 1) != 0) s = (s >> 1) ^ 'h8408;
      else                           s = s >> 1;
    end
    return s & 'hFFFF;
  endfunction

  // Behavioural reference model, updated on each clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_crc <= 'hFFFF;
      m_cnt <= 0;
    end else if (bus_en && bus_we) begin
      if (bus_addr == 2'd0 && bus_wdata[15]) begin
        m_crc <= 'hFFFF;
        m_cnt <= 0;
      end else if (bus_addr == 2'd1) begin
        m_crc <= step_byte(m_crc, bus_wdata & 'hFF);
        m_cnt <= (m_cnt < 4095) ? m_cnt + 1 : 4095;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (bus_en && !bus_we && bus_addr == 2'd0)
        check(bus_rdata == 16'(m_cnt), "R3 model ctrl", bus_rdata, m_cnt);
      else if (bus_en && !bus_we && bus_addr == 2'd2)
        check(bus_rdata == 16'(m_crc ^ 'hFFFF), "R5 model result", bus_rdata, m_crc ^ 'hFFFF);
      else
        check(bus_rdata == 16'd0, "R8 model idle/unmapped", bus_rdata, 0);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd_exp(input logic [1:0] a, input int exp, input string tag);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = 16'd0;
    @(negedge clk);
    check(bus_rdata == 16'(exp), tag, bus_rdata, exp);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int e;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values
    rd_exp(2'd0, 0, "R1 count after reset");
    rd_exp(2'd2, 'h0000, "R1 result after reset");

    // R6: known-answer vector
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h00CC); wr(2'd1, 16'h00F5); wr(2'd1, 16'h00F1); wr(2'd1, 16'h00A7);
    rd_exp(2'd0, 4, "R6 kat count");
    rd_exp(2'd2, 'h51DF, "R6 kat result");

    // R2: control write without bit 15
    wr(2'd0, 16'h7FFF);
    rd_exp(2'd0, 4, "R2 no-clear ctrl write count");
    rd_exp(2'd2, 'h51DF, "R2 no-clear ctrl write result");

    // R9: write pattern with strobe low
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0055;
    @(posedge clk); #1;
    bus_addr = 2'd0; bus_wdata = 16'h8000;
    rd_exp(2'd0, 4, "R9 strobe-low count");
    rd_exp(2'd2, 'h51DF, "R9 strobe-low result");

    // R8: input register and unused word read as zero
    rd_exp(2'd1, 0, "R8 read input reg");
    rd_exp(2'd3, 0, "R8 read word 3");

    // R4: high bits ignored
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'hABCC);
    e = step_byte('hFFFF, 'hCC) ^ 'hFFFF;
    rd_exp(2'd2, e, "R4 high bits ignored");
    rd_exp(2'd0, 1, "R4 count one");

    // R5: longer varied pattern
    wr(2'd0, 16'h8000);
    e = 'hFFFF;
    for (int i = 0; i < 24; i++) begin
      int b = (i * 37 + 11) & 'hFF;
      wr(2'd1, 16'(b | ((i * 5) << 8)));
      e = step_byte(e, b);
      if (i % 6 == 5) rd_exp(2'd2, e ^ 'hFFFF, "R5 running result");
    end
    rd_exp(2'd0, 24, "R3 count 24");

    // R7: saturation
    wr(2'd0, 16'h8000);
    for (int i = 0; i < 4100; i++) wr(2'd1, 16'(i));
    rd_exp(2'd0, 4095, "R7 saturated count");
    wr(2'd1, 16'h0001);
    rd_exp(2'd0, 4095, "R7 stays saturated");

    // R2: clear from saturation
    wr(2'd0, 16'h8000);
    rd_exp(2'd0, 0, "R2 clear count");
    rd_exp(2'd2, 'h0000, "R2 clear result");

    idle();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule